// File: doc/BRIEF.md
# Multi-Sector Block Transfer Sequencer

This block paces a multi-sector data transfer in groups of sectors instead of single sectors. A set-block command picks a group size. After that, each read-blocks or write-blocks command asks for a number of sectors. The block splits that number into whole groups of the chosen size, followed by one shorter group when sectors are left over. It raises the data request line for each group and gives one interrupt pulse when a group is finished.

Commands are accepted only while the sequencer is idle. A read-blocks or write-blocks command is rejected with an abort pulse when no valid group size has been set. A sector error during a transfer stops it, and the address of the failing sector is latched. A hardware reset clears the group mode. A synchronous soft reset ends any transfer but keeps the mode and the group size.

Top module: `blk_xfer_seq`

## Requirements
- R1: After hardware reset `drq`, `intrPulse` and `abortPulse` are low, `failLba` is zero and group mode is disabled.
- R2: In idle, a set-block command (`cmdOp`=0) whose `cmdCount` is 1, 2, 4, 8 or 16 enables group mode with that size and gives one `intrPulse` in the cycle after the command.
- R3: A set-block command with any other `cmdCount` gives one `abortPulse` in the cycle after the command and disables group mode.
- R4: A read-blocks (`cmdOp`=1) or write-blocks (`cmdOp`=2) command while group mode is disabled gives one `abortPulse` in the next cycle and never raises `drq`.
- R5: An accepted read-blocks or write-blocks command raises `drq` in the next cycle. `drq` stays high until the `secDone` that ends the group. In the cycle after that, `drq` is low and `intrPulse` is high for one cycle. If sectors remain, `drq` rises again in the following cycle.
- R6: A transfer of N sectors with group size S is made of floor(N/S) groups of S sectors, then one group of N mod S sectors if that is non-zero. This gives ceil(N/S) interrupt pulses.
- R7: With `cmdWide`=0 only `cmdCount[7:0]` counts and 0 means 256 sectors. With `cmdWide`=1 all 16 bits count and 0 means 65536.
- R8: A `secErr` during a transfer ends it. In the next cycle `drq` is low, `abortPulse` is high, and `failLba` equals `cmdLba` plus the number of sectors already finished.
- R9: `softRst` ends any transfer: `drq` is low in the next cycle and no pulse follows. Group mode and group size are kept.
- R10: Asserting `rstN` low after group mode was enabled disables it again. A later read-blocks command is then aborted.
- R11: Commands during a transfer, `cmdOp`=3, and `secDone` outside a transfer are ignored. They produce no pulse and no change in group size.
- R12: The group size used is the one given by the most recent accepted set-block command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low; clears group mode |
| softRst | input | 1 | Synchronous soft reset; ends the transfer and keeps the mode |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 2 | 0 set-block, 1 read-blocks, 2 write-blocks, 3 none |
| cmdCount | input | 16 | Group size for set-block; sector count otherwise |
| cmdWide | input | 1 | 1 selects the 16-bit count form |
| cmdLba | input | 48 | Address of the first sector |
| secDone | input | 1 | One sector moved |
| secErr | input | 1 | Current sector failed |
| drq | output | 1 | Data request for the current group |
| intrPulse | output | 1 | One-cycle interrupt at group or set-block completion |
| abortPulse | output | 1 | One-cycle abort or error indication |
| failLba | output | 48 | Address of the last failing sector |

## Verification
The bench aims at counts that are not a multiple of the group size, and at the 8-bit zero count. A design that got the rounding wrong would give one interrupt too many or too few, or would end the transfer after zero sectors. It also sends a sector error in the middle of the second group. A design with an off-by-one in the address counter would latch the wrong `failLba`, and one that keeps going would leave `drq` high. A soft reset is followed by a read-blocks command, and so is a hardware reset. Mixing up the two reset kinds shows as a missing or an unexpected abort. Set-block commands are sent during a transfer. A design that accepts them would change the group pacing in the middle of the transfer.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    OP_SET_BLOCK    = 2'd0,
    OP_READ_BLOCKS  = 2'd1,
    OP_WRITE_BLOCKS = 2'd2,
    OP_NONE         = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MOVE = 2'd1,
    PH_GAP  = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setMode;
    logic clrMode;
    logic loadCmd;
    logic step;
    logic capErr;
    logic nextBlk;
  } ctrlStrb_t;

endpackage

// File: rtl/blk_xfer_dp.sv
module blk_xfer_dp
  import blk_xfer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int LBA_W    = 48,
  parameter int MAX_BLK  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             cmdWide,
  input  logic [LBA_W-1:0] cmdLba,
  output logic             modeEn,
  output logic             sizeOk,
  output logic             lastInBlk,
  output logic             allDone,
  output logic [LBA_W-1:0] failLba
);

  localparam int REM_W = CNT_W + 1;
  localparam int BLK_W = $clog2(MAX_BLK) + 1;

  logic [BLK_W-1:0] blkSize;
  logic [BLK_W-1:0] blkLeft;
  logic [REM_W-1:0] remaining;
  logic [REM_W-1:0] effCount;
  logic [LBA_W-1:0] curLba;

  function automatic logic [BLK_W-1:0] clipBlk(input logic [REM_W-1:0] n,
                                               input logic [BLK_W-1:0] s);
    return (n >= REM_W'(s)) ? s : n[BLK_W-1:0];
  endfunction

  // count decode: zero stands for the full range of the chosen form
  always_comb begin
    if (cmdWide) begin
      effCount = (cmdCount == '0) ? (REM_W'(1) << CNT_W) : {1'b0, cmdCount};
    end else begin
      effCount = (cmdCount[NARROW_W-1:0] == '0) ? (REM_W'(1) << NARROW_W)
                                                : REM_W'(cmdCount[NARROW_W-1:0]);
    end
  end

  assign sizeOk    = $onehot(cmdCount) && (cmdCount <= CNT_W'(MAX_BLK));
  assign lastInBlk = (blkLeft == BLK_W'(1));
  assign allDone   = (remaining == '0);

  // mode state: only hardware reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      blkSize <= '0;
    end else if (strb.setMode) begin
      modeEn  <= 1'b1;
      blkSize <= cmdCount[BLK_W-1:0];
    end else if (strb.clrMode) begin
      modeEn  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      blkLeft   <= '0;
      curLba    <= '0;
    end else if (strb.loadCmd) begin
      remaining <= effCount;
      blkLeft   <= clipBlk(effCount, blkSize);
      curLba    <= cmdLba;
    end else if (strb.step) begin
      remaining <= remaining - REM_W'(1);
      blkLeft   <= blkLeft - BLK_W'(1);
      curLba    <= curLba + LBA_W'(1);
    end else if (strb.nextBlk) begin
      blkLeft   <= clipBlk(remaining, blkSize);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failLba <= '0;
    end else if (strb.capErr) begin
      failLba <= curLba;
    end
  end

endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       secDone,
  input  logic       secErr,
  input  logic       modeEn,
  input  logic       sizeOk,
  input  logic       lastInBlk,
  input  logic       allDone,
  output ctrlStrb_t  strb,
  output logic       drq,
  output logic       intrPulse,
  output logic       abortPulse
);

  phase_e ph, phNext;
  cmdOp_e opK;
  logic   isSet, isRw, inIdle, inMove, inGap, rejRw;

  assign opK    = cmdOp_e'(cmdOp);
  assign isSet  = cmdValid && (opK == OP_SET_BLOCK);
  assign isRw   = cmdValid && ((opK == OP_READ_BLOCKS) || (opK == OP_WRITE_BLOCKS));
  assign inIdle = (ph == PH_IDLE) && !softRst;
  assign inMove = (ph == PH_MOVE) && !softRst;
  assign inGap  = (ph == PH_GAP)  && !softRst;

  always_comb begin
    strb         = '0;
    strb.setMode = inIdle && isSet && sizeOk;
    strb.clrMode = inIdle && isSet && !sizeOk;
    strb.loadCmd = inIdle && isRw && modeEn;
    strb.step    = inMove && secDone && !secErr;
    strb.capErr  = inMove && secErr;
    strb.nextBlk = inGap && !allDone;
  end

  assign rejRw = inIdle && isRw && !modeEn;

  always_comb begin
    phNext = ph;
    if (softRst) begin
      phNext = PH_IDLE;
    end else begin
      unique case (ph)
        PH_IDLE: if (strb.loadCmd) phNext = PH_MOVE;
        PH_MOVE: begin
          if (strb.capErr)                   phNext = PH_IDLE;
          else if (strb.step && lastInBlk)   phNext = PH_GAP;
        end
        PH_GAP:  phNext = allDone ? PH_IDLE : PH_MOVE;
        default: phNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph         <= PH_IDLE;
      drq        <= 1'b0;
      intrPulse  <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      ph         <= phNext;
      drq        <= (phNext == PH_MOVE);
      intrPulse  <= strb.setMode || (strb.step && lastInBlk);
      abortPulse <= strb.clrMode || rejRw || strb.capErr;
    end
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int LBA_W    = 48,
  parameter int MAX_BLK  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             cmdWide,
  input  logic [LBA_W-1:0] cmdLba,
  input  logic             secDone,
  input  logic             secErr,
  output logic             drq,
  output logic             intrPulse,
  output logic             abortPulse,
  output logic [LBA_W-1:0] failLba
);

  ctrlStrb_t strb;
  logic      modeEn, sizeOk, lastInBlk, allDone;

  blk_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .secDone    (secDone),
    .secErr     (secErr),
    .modeEn     (modeEn),
    .sizeOk     (sizeOk),
    .lastInBlk  (lastInBlk),
    .allDone    (allDone),
    .strb       (strb),
    .drq        (drq),
    .intrPulse  (intrPulse),
    .abortPulse (abortPulse)
  );

  blk_xfer_dp #(
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W),
    .LBA_W    (LBA_W),
    .MAX_BLK  (MAX_BLK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdCount  (cmdCount),
    .cmdWide   (cmdWide),
    .cmdLba    (cmdLba),
    .modeEn    (modeEn),
    .sizeOk    (sizeOk),
    .lastInBlk (lastInBlk),
    .allDone   (allDone),
    .failLba   (failLba)
  );

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk (
  input logic clk,
  input logic rstN,
  input logic softRst,
  input logic secDone,
  input logic secErr,
  input logic drq,
  input logic intrPulse,
  input logic abortPulse
);

  // R5: a group-completion interrupt comes with the request line low
  a_r5_intr_without_drq: assert property (@(posedge clk) disable iff (!rstN)
    intrPulse |-> !drq);

  // R4: an abort never overlaps an active request
  a_r4_abort_without_drq: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !drq);

  // R11: a single command or event gives at most one kind of response
  a_r11_one_response: assert property (@(posedge clk) disable iff (!rstN)
    !(intrPulse && abortPulse));

  // R5: the request line only falls after a sector event or a soft reset
  a_r5_drq_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drq) |-> $past(secDone || secErr || softRst));

  // R5: with no sector event the request line holds
  a_r5_drq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (drq && !secDone && !secErr && !softRst) |=> drq);

  // R8: a sector error stops the transfer and reports an abort
  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    (drq && secErr && !softRst) |=> (!drq && abortPulse));

  // R9: soft reset leaves everything quiet
  a_r9_soft_quiet: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!drq && !intrPulse && !abortPulse));

endmodule

bind blk_xfer_seq blk_xfer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .softRst    (softRst),
  .secDone    (secDone),
  .secErr     (secErr),
  .drq        (drq),
  .intrPulse  (intrPulse),
  .abortPulse (abortPulse)
);

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd3;
  logic [15:0] cmdCount = '0;
  logic        cmdWide = 1'b0;
  logic [47:0] cmdLba = '0;
  logic        secDone = 1'b0;
  logic        secErr = 1'b0;
  logic        drq, intrPulse, abortPulse;
  logic [47:0] failLba;

  int total = 0;
  int bad = 0;
  int intrCnt = 0;
  int abortCnt = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  blk_xfer_seq u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdCount(cmdCount), .cmdWide(cmdWide), .cmdLba(cmdLba),
    .secDone(secDone), .secErr(secErr), .drq(drq), .intrPulse(intrPulse),
    .abortPulse(abortPulse), .failLba(failLba)
  );

  task automatic chkEq(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int     mMode, mSize, mPh, mRem, mBlk;
  longint mLba, mFail;
  int     eDrq, eIntr, eAbort;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mSize = 0; mPh = 0; mRem = 0; mBlk = 0;
      mLba = 0; mFail = 0; eDrq = 0; eIntr = 0; eAbort = 0;
    end else begin
      eIntr = 0; eAbort = 0;
      if (softRst) begin
        mPh = 0;
      end else if (mPh == 0) begin
        if (cmdValid && cmdOp == 2'd0) begin
          if (cmdCount == 1 || cmdCount == 2 || cmdCount == 4 ||
              cmdCount == 8 || cmdCount == 16) begin
            mMode = 1; mSize = int'(cmdCount); eIntr = 1;
          end else begin
            mMode = 0; eAbort = 1;
          end
        end else if (cmdValid && (cmdOp == 2'd1 || cmdOp == 2'd2)) begin
          if (mMode == 0) eAbort = 1;
          else begin
            if (cmdWide) mRem = (cmdCount == 0) ? 65536 : int'(cmdCount);
            else mRem = (cmdCount[7:0] == 0) ? 256 : int'(cmdCount[7:0]);
            mBlk = (mRem >= mSize) ? mSize : mRem;
            mLba = longint'(cmdLba);
            mPh = 1;
          end
        end
      end else if (mPh == 1) begin
        if (secErr) begin
          mFail = mLba; eAbort = 1; mPh = 0;
        end else if (secDone) begin
          mRem--; mBlk--; mLba++;
          if (mBlk == 0) begin eIntr = 1; mPh = 2; end
        end
      end else begin
        if (mRem == 0) mPh = 0;
        else begin mBlk = (mRem >= mSize) ? mSize : mRem; mPh = 1; end
      end
      eDrq = (mPh == 1) ? 1 : 0;
    end
  end

  // per-cycle comparison and pulse counting
  always @(negedge clk) begin
    if (rstN) begin
      chkEq(curTag, "drq", drq, eDrq);
      chkEq(curTag, "intrPulse", intrPulse, eIntr);
      chkEq(curTag, "abortPulse", abortPulse, eAbort);
      chkEq(curTag, "failLba", failLba, mFail);
    end
    if (intrPulse) intrCnt++;
    if (abortPulse) abortCnt++;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] op, logic [15:0] cnt, logic wide, logic [47:0] lba);
    cmdOp = op; cmdCount = cnt; cmdWide = wide; cmdLba = lba; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd3;
  endtask

  task automatic doSectors(int n, int errAt);
    for (int i = 0; i < n; i++) begin
      while (!drq) @(negedge clk);
      if (i == errAt) secErr = 1'b1; else secDone = 1'b1;
      @(negedge clk);
      secDone = 1'b0; secErr = 1'b0;
      if (i == errAt) break;
    end
    idle(3);
  endtask

  // one full transfer, with the interrupt count checked against ceil(n/s)
  task automatic xfer(string tag, logic [1:0] op, int n, int s, logic wide, logic [15:0] cnt);
    int i0, a0;
    i0 = intrCnt; a0 = abortCnt;
    issue(op, cnt, wide, 48'h100);
    doSectors(n, -1);
    chkEq(tag, "interrupt count", intrCnt - i0, (n + s - 1) / s);
    chkEq(tag, "abort count", abortCnt - a0, 0);
    chkEq(tag, "drq after end", drq, 0);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements act=hung exp=finished");
    finishRun();
  end

  initial begin
    int i0, a0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1: reset state
    curTag = "R1";
    chkEq("R1", "drq at reset", drq, 0);
    chkEq("R1", "intr at reset", intrPulse, 0);
    chkEq("R1", "failLba at reset", failLba, 0);
    // R4: read-blocks with mode disabled after reset
    curTag = "R4";
    a0 = abortCnt;
    issue(2'd1, 16'd4, 1'b0, 48'h0); idle(3);
    chkEq("R4", "abort on disabled mode", abortCnt - a0, 1);

    // R3: unsupported sizes
    curTag = "R3";
    a0 = abortCnt;
    issue(2'd0, 16'd3, 1'b0, 48'h0); idle(2);
    issue(2'd0, 16'd0, 1'b0, 48'h0); idle(2);
    issue(2'd0, 16'd32, 1'b0, 48'h0); idle(2);
    chkEq("R3", "abort on bad size", abortCnt - a0, 3);
    issue(2'd0, 16'd4, 1'b0, 48'h0); idle(2);
    issue(2'd0, 16'd5, 1'b0, 48'h0); idle(2);
    a0 = abortCnt;
    issue(2'd2, 16'd4, 1'b0, 48'h0); idle(3);
    chkEq("R3", "write aborted after bad size", abortCnt - a0, 1);

    // R2, R5, R6: size 4, 10 sectors -> 4,4,2
    curTag = "R2";
    i0 = intrCnt;
    issue(2'd0, 16'd4, 1'b0, 48'h0); idle(2);
    chkEq("R2", "set-block interrupt", intrCnt - i0, 1);
    curTag = "R6";
    xfer("R6", 2'd1, 10, 4, 1'b0, 16'd10);
    curTag = "R5";
    xfer("R5", 2'd2, 3, 4, 1'b0, 16'd3);

    // R12: latest accepted size is used
    curTag = "R12";
    issue(2'd0, 16'd8, 1'b0, 48'h0); idle(2);
    xfer("R12", 2'd2, 20, 8, 1'b0, 16'd20);
    issue(2'd0, 16'd16, 1'b0, 48'h0); idle(2);
    xfer("R12", 2'd1, 16, 16, 1'b0, 16'd16);
    issue(2'd0, 16'd1, 1'b0, 48'h0); idle(2);
    xfer("R12", 2'd1, 3, 1, 1'b0, 16'd3);

    // R7: count forms
    curTag = "R7";
    issue(2'd0, 16'd16, 1'b0, 48'h0); idle(2);
    xfer("R7", 2'd1, 256, 16, 1'b0, 16'h0000);
    xfer("R7", 2'd2, 300, 16, 1'b1, 16'd300);
    xfer("R7", 2'd1, 44, 16, 1'b0, 16'h012C);

    // R8: error in the second group
    curTag = "R8";
    issue(2'd0, 16'd4, 1'b0, 48'h0); idle(2);
    i0 = intrCnt; a0 = abortCnt;
    issue(2'd2, 16'd10, 1'b0, 48'd1000);
    doSectors(10, 6);
    chkEq("R8", "failLba", failLba, 1006);
    chkEq("R8", "abort on error", abortCnt - a0, 1);
    chkEq("R8", "groups finished before error", intrCnt - i0, 1);
    chkEq("R8", "drq after error", drq, 0);

    // R9: soft reset mid transfer keeps mode and size
    curTag = "R9";
    issue(2'd0, 16'd2, 1'b0, 48'h0); idle(2);
    issue(2'd1, 16'd6, 1'b0, 48'h0);
    doSectors(3, -1);
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    chkEq("R9", "drq after soft reset", drq, 0);
    idle(2);
    xfer("R9", 2'd1, 5, 2, 1'b0, 16'd5);

    // R11: commands during a transfer and stray events are ignored
    curTag = "R11";
    issue(2'd0, 16'd4, 1'b0, 48'h0); idle(2);
    i0 = intrCnt; a0 = abortCnt;
    issue(2'd1, 16'd8, 1'b0, 48'h0);
    doSectors(2, -1);
    issue(2'd0, 16'd1, 1'b0, 48'h0);
    issue(2'd0, 16'd3, 1'b0, 48'h0);
    issue(2'd3, 16'd2, 1'b0, 48'h0);
    doSectors(6, -1);
    chkEq("R11", "busy commands ignored", intrCnt - i0, 2);
    chkEq("R11", "no abort from busy commands", abortCnt - a0, 0);
    i0 = intrCnt;
    secDone = 1'b1; idle(3); secDone = 1'b0; idle(2);
    issue(2'd3, 16'd1, 1'b0, 48'h0); idle(2);
    chkEq("R11", "idle events ignored", intrCnt - i0, 0);
    xfer("R11", 2'd2, 4, 4, 1'b0, 16'd4);

    // R10: hardware reset clears the mode
    curTag = "R10";
    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    a0 = abortCnt;
    issue(2'd1, 16'd4, 1'b0, 48'h0); idle(3);
    chkEq("R10", "abort after hardware reset", abortCnt - a0, 1);
    chkEq("R10", "drq stays low", drq, 0);

    idle(2);
    finishRun();
  end

endmodule